// File: doc/BRIEF.md
# Dual Reloading Interval Timer

This block holds two down-counting interval timers behind a small register-write port. The wide timer (10 bits) steps once for every pulse of a prescaled tick enable. The narrow timer (8 bits) steps once for every sixteen such pulses. Each timer has its own reload register. A control register sets, per timer, whether it starts, stops, can raise an interrupt, and whether its flag is cleared.

A counter idles at zero. Software arms it by writing its reload value and then writing a start bit of 1. The counter then counts toward zero. On the step that takes it from one to zero, it reloads from its reload register and keeps running. If that timer's interrupt enable is set at that moment, its status flag is set. The interrupt output stays high while either flag is set. A start bit of 0 forces the counter back to zero.

Two further control bits, a three-slot option and an automatic key-on option, are only held and brought out as configuration outputs. A status byte reports both flags and a busy bit, which is high for a few clocks after each register write.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counters are zero, both flags are clear, `irq` is 0, `status` is 0x00 and both configuration outputs are 0.
- R2: The wide timer's reload value is set by two writes. A write to address 0x24 sets reload bits 9..2 from data bits 7..0. A write to address 0x25 sets reload bits 1..0 from data bits 1..0, and data bits 7..2 of that write are discarded. The narrow timer's reload value is written at address 0x26.
- R3: The control register is at address 0x27. Bit 0 is the wide timer's start bit and bit 1 is the narrow timer's start bit. A start bit of 1 copies the reload register into that counter only if the counter is zero; if the counter is nonzero, the write leaves it unchanged.
- R4: A start bit of 0 in a control write forces that counter to zero. A counter at zero stays there and never expires.
- R5: A nonzero wide counter decrements once per `tick_en` pulse. When a counter loaded with N > 0 has received N steps, it expires. On expiry it reloads from the reload register's current value and runs on, so it expires again every N steps.
- R6: The narrow counter steps on every sixteenth `tick_en` pulse counted since reset (the 16th, 32nd, ...). A free-running divider counts these pulses whatever the counters are doing.
- R7: On expiry, a timer's flag is set only if that timer's interrupt enable is set. Control bit 2 is the wide timer's enable and bit 3 is the narrow timer's enable. The wide timer's flag is `status` bit 0 and the narrow timer's flag is `status` bit 1.
- R8: In a control write, bit 4 = 1 clears the wide timer's flag and bit 5 = 1 clears the narrow timer's flag. A 0 in either bit leaves that flag unchanged.
- R9: `irq` is the OR of the two flags. It stays high until the flags are cleared by a control write.
- R10: `status` bit 7 (busy) is 1 for BUSY_CYCLES clock cycles after any accepted write, 4 by default. `status` bits 6..2 are 0.
- R11: Control bit 6 is held on `cfg_three_slot` and control bit 7 is held on `cfg_auto_key`. Neither bit has any effect on the counters or the flags.
- R12: A write to any address other than 0x24..0x27 changes no reload value, no control setting, no flag and no configuration output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaled tick; one step for the wide timer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| irq | output | 1 | Active-high interrupt request |
| status | output | 8 | {busy, 5'b0, narrow flag, wide flag} |
| cfg_three_slot | output | 1 | Held control bit 6 |
| cfg_auto_key | output | 1 | Held control bit 7 |

## Verification
The hardest case to reach from the ports is a start request that arrives while a counter is already running. The counters cannot be read, so the ignored request shows up only through when the next expiry happens. The stimulus arms the wide timer, lets a few ticks pass, then writes a different reload value and a start bit of 1. It then checks that the flag rises on the tick set by the first value, and that the following period uses the new value. The narrow timer's timing depends on the phase of the divider since reset. The bench therefore counts every tick it issues and derives each expected expiry tick arithmetically from that count.

// File: rtl/dit_pkg.sv
// Package: register addresses and control-word layout shared by the
// dual interval timer. Assumes an 8-bit write data path.
package dit_pkg;
    localparam logic [7:0] ADDR_A_HI  = 8'h24;
    localparam logic [7:0] ADDR_A_LO  = 8'h25;
    localparam logic [7:0] ADDR_B     = 8'h26;
    localparam logic [7:0] ADDR_CTRL  = 8'h27;

    typedef struct packed {
        logic auto_key;    // bit 7
        logic three_slot;  // bit 6
        logic clr_b;       // bit 5
        logic clr_a;       // bit 4
        logic irq_en_b;    // bit 3
        logic irq_en_a;    // bit 2
        logic start_b;     // bit 1
        logic start_a;     // bit 0
    } ctrl_t;
endpackage

// File: rtl/dit_regs.sv
// Register file: decodes writes into the reload registers and held control
// settings, and passes the raw control word through as a one-cycle command.
// Assumes A_W - 2 <= 8 and B_W <= 8.
module dit_regs
    import dit_pkg::*;
#(
    parameter int A_W = 10,
    parameter int B_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [7:0]     wr_addr,
    input  logic [7:0]     wr_data,
    output logic [A_W-1:0] reload_a,
    output logic [B_W-1:0] reload_b,
    output logic           ctrl_wr,
    output ctrl_t          ctrl_cmd,
    output logic           irq_en_a,
    output logic           irq_en_b,
    output logic           three_slot,
    output logic           auto_key
);
    localparam int A_HI_W = A_W - 2;

    logic mapped;

    // Decode the control strobe and the set of addresses that are mapped.
    always_comb begin
        ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
        ctrl_cmd = ctrl_t'(wr_data);
        mapped   = (wr_addr == ADDR_A_HI) || (wr_addr == ADDR_A_LO) ||
                   (wr_addr == ADDR_B)    || (wr_addr == ADDR_CTRL);
    end

    // Capture the reload registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_a <= '0;
            reload_b <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_A_HI) reload_a[A_W-1:2] <= wr_data[A_HI_W-1:0];
            if (wr_addr == ADDR_A_LO) reload_a[1:0]     <= wr_data[1:0];
            if (wr_addr == ADDR_B)    reload_b          <= wr_data[B_W-1:0];
        end
    end

    // Hold the enables and configuration bits from the last control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_a   <= 1'b0;
            irq_en_b   <= 1'b0;
            three_slot <= 1'b0;
            auto_key   <= 1'b0;
        end else if (ctrl_wr) begin
            irq_en_a   <= ctrl_cmd.irq_en_a;
            irq_en_b   <= ctrl_cmd.irq_en_b;
            three_slot <= ctrl_cmd.three_slot;
            auto_key   <= ctrl_cmd.auto_key;
        end
    end

    // R12: unmapped writes leave every held setting unchanged
    assert_unmapped_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mapped) |=> ($stable(reload_a) && $stable(reload_b) &&
                                $stable(irq_en_a) && $stable(irq_en_b) &&
                                $stable(three_slot) && $stable(auto_key)));
endmodule

// File: rtl/dit_prescale.sv
// Free-running tick divider: asserts step_out on every 2**DIV_LOG2-th
// tick_en pulse counted since reset. Assumes DIV_LOG2 >= 1.
module dit_prescale #(
    parameter int DIV_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic step_out
);
    logic [DIV_LOG2-1:0] phase;

    // Step on the tick that wraps the divider.
    always_comb step_out = tick_en && (&phase);

    // Count every tick pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (tick_en) phase <= phase + 1'b1;
    end

    // R6: two divided steps are never adjacent
    assert_step_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_out |=> !step_out);
endmodule

// File: rtl/dit_counter.sv
// One reloading down-counter with its expiry flag. A start command loads
// the counter only from zero, a stop command zeroes it; steps move a nonzero
// counter toward zero and reload on expiry. Commands take priority over steps.
module dit_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         cmd_wr,
    input  logic         cmd_start,
    input  logic         irq_en,
    input  logic         flag_clr,
    input  logic [W-1:0] reload,
    output logic         flag,
    output logic         expire
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] cnt;

    // Expiry is the step that takes the counter from one to zero.
    always_comb expire = step && !cmd_wr && (cnt == ONE);

    // Apply commands, steps and automatic reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= ZERO;
        end else if (cmd_wr) begin
            if (!cmd_start)       cnt <= ZERO;
            else if (cnt == ZERO) cnt <= reload;
        end else if (step && (cnt != ZERO)) begin
            if (cnt == ONE) cnt <= reload;
            else            cnt <= cnt - ONE;
        end
    end

    // Clear-then-set update of the flag, so an expiry is never lost.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= (flag & ~flag_clr) | (expire & irq_en);
    end

    // R4: a stop command zeroes the counter
    assert_stop_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_start) |=> (cnt == ZERO));
    // R3: an idle counter stays idle without a command
    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == ZERO) && !cmd_wr) |=> (cnt == ZERO));
    // R5: expiry reloads from the reload register
    assert_expiry_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt == $past(reload)));
    // R7: a flag only rises with its enable set
    assert_flag_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(irq_en));
endmodule

// File: rtl/dit_busy.sv
// Busy window: holds busy high for BUSY_CYCLES clocks after each write.
// Assumes BUSY_CYCLES >= 1.
module dit_busy #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    output logic busy
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);
    localparam logic [BW-1:0] FULL = BW'(BUSY_CYCLES);

    logic [BW-1:0] left;

    // Restart the window on each write, otherwise count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)           left <= '0;
        else if (wr_en)       left <= FULL;
        else if (left != '0)  left <= left - 1'b1;
    end

    always_comb busy = (left != '0);

    // R10: a write makes busy visible on the next cycle
    assert_busy_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> busy);
    // R10: busy never rises without a write
    assert_busy_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_en) |=> !busy);
endmodule

// File: rtl/dual_interval_timer.sv
// Top: two reloading interval timers behind a register-write port. The wide
// timer steps on tick_en, the narrow one on every 2**DIV_LOG2-th tick. Status
// gives both flags and a busy bit; irq is the OR of the flags.
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int A_W         = 10,
    parameter int B_W         = 8,
    parameter int DIV_LOG2    = 4,
    parameter int BUSY_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       irq,
    output logic [7:0] status,
    output logic       cfg_three_slot,
    output logic       cfg_auto_key
);
    logic [A_W-1:0] reload_a;
    logic [B_W-1:0] reload_b;
    logic           ctrl_wr;
    ctrl_t          ctrl_cmd;
    logic           irq_en_a, irq_en_b;
    logic           step_b;
    logic           flag_a, flag_b, expire_a, expire_b;
    logic           busy;

    dit_regs #(.A_W(A_W), .B_W(B_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .reload_a(reload_a), .reload_b(reload_b),
        .ctrl_wr(ctrl_wr), .ctrl_cmd(ctrl_cmd), .irq_en_a(irq_en_a),
        .irq_en_b(irq_en_b), .three_slot(cfg_three_slot), .auto_key(cfg_auto_key)
    );

    dit_prescale #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .step_out(step_b)
    );

    dit_counter #(.W(A_W)) u_cnt_a (
        .clk(clk), .rst_n(rst_n), .step(tick_en), .cmd_wr(ctrl_wr),
        .cmd_start(ctrl_cmd.start_a), .irq_en(irq_en_a),
        .flag_clr(ctrl_wr && ctrl_cmd.clr_a), .reload(reload_a),
        .flag(flag_a), .expire(expire_a)
    );

    dit_counter #(.W(B_W)) u_cnt_b (
        .clk(clk), .rst_n(rst_n), .step(step_b), .cmd_wr(ctrl_wr),
        .cmd_start(ctrl_cmd.start_b), .irq_en(irq_en_b),
        .flag_clr(ctrl_wr && ctrl_cmd.clr_b), .reload(reload_b),
        .flag(flag_b), .expire(expire_b)
    );

    dit_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy)
    );

    // Assemble the status byte and the interrupt request.
    always_comb begin
        status = {busy, 5'b0, flag_b, flag_a};
        irq    = flag_a | flag_b;
    end

    // R9: irq only falls after a control write
    assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(ctrl_wr));
    // R11: the configuration bits only move on a control write
    assert_cfg_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> ($stable(cfg_three_slot) && $stable(cfg_auto_key)));
    // R5: an expiry reaches the flag when enabled
    assert_expire_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_a && irq_en_a) |=> flag_a);
    assert_expire_b_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_b && irq_en_b) |=> flag_b);
endmodule

// File: tb/sim_dual_interval_timer.sv
module sim_dual_interval_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       irq;
    logic [7:0] status;
    logic       cfg_three_slot, cfg_auto_key;

    int n_chk = 0;
    int n_bad = 0;
    int ticks = 0;

    always #5 clk = ~clk;

    dual_interval_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq), .status(status),
        .cfg_three_slot(cfg_three_slot), .cfg_auto_key(cfg_auto_key)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (tick %0d)", req, act, exp, ticks);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        ticks++;
    endtask

    // Load the wide reload register with v (junk in unused low-write bits).
    task automatic set_a(input int v);
        wr(8'h24, 8'(v >> 2));
        wr(8'h25, 8'hFC | 8'(v & 3));
    endtask

    // n ticks; the wide flag must rise exactly on tick n when expected.
    task automatic run_a(input string req, input int n, input bit fires);
        for (int k = 1; k <= n; k++) begin
            tick();
            chk(req, int'(status[0]), (fires && k == n) ? 1 : 0);
        end
        chk(req, int'(irq), fires ? 1 : 0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", int'(status), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 cfg", int'({cfg_auto_key, cfg_three_slot}), 0);

        // R12: unmapped writes have no visible effect
        wr(8'h23, 8'hFF); wr(8'h28, 8'hFF); wr(8'h00, 8'hFF);
        chk("R12 cfg", int'({cfg_auto_key, cfg_three_slot}), 0);
        chk("R12 flags", int'(status[1:0]), 0);

        // R10: busy window after a write
        wr(8'h40, 8'h00);
        chk("R10 busy start", int'(status[7]), 1);
        repeat (3) @(negedge clk);
        chk("R10 busy last", int'(status[7]), 1);
        @(negedge clk);
        chk("R10 busy end", int'(status[7]), 0);
        chk("R10 pad bits", int'(status[6:2]), 0);

        // R2 R5 sweep over wide reload values, with automatic reload
        for (int n = 1; n <= 17; n++) begin
            int v;
            v = (n == 17) ? 1023 : n;
            set_a(v);
            wr(8'h27, 8'h34);   // stop both, clear flags
            wr(8'h27, 8'h05);   // start A, enable A
            run_a("R5 first period", v, 1'b1);
            wr(8'h27, 8'h15);   // clear A flag, start no-op while running
            run_a("R5 reload period", v, 1'b1);
            wr(8'h27, 8'h10);   // stop, clear
        end

        // R12: junk between reload write and start does not alter the value
        set_a(3);
        wr(8'h2A, 8'hFF); wr(8'h1F, 8'h00);
        wr(8'h27, 8'h05);
        run_a("R12 reload kept", 3, 1'b1);
        wr(8'h27, 8'h10);

        // R3: start while running is ignored; reload picks up the new value
        set_a(10);
        wr(8'h27, 8'h05);
        run_a("R3 pre", 3, 1'b0);
        set_a(5);
        wr(8'h27, 8'h05);
        run_a("R3 ignored start", 7, 1'b1);
        wr(8'h27, 8'h15);
        run_a("R3 new reload", 5, 1'b1);
        wr(8'h27, 8'h10);

        // R4: stop zeroes the counter; restart from zero loads again
        set_a(8);
        wr(8'h27, 8'h05);
        run_a("R4 pre", 3, 1'b0);
        wr(8'h27, 8'h04);
        run_a("R4 stopped", 20, 1'b0);
        set_a(5);
        wr(8'h27, 8'h05);
        run_a("R4 restart", 5, 1'b1);
        wr(8'h27, 8'h10);

        // R7: no flag with enable off, though the counter keeps reloading
        set_a(4);
        wr(8'h27, 8'h01);
        run_a("R7 disabled", 8, 1'b0);
        wr(8'h27, 8'h05);
        run_a("R7 enabled", 4, 1'b1);
        wr(8'h27, 8'h10);

        // R6: narrow timer steps on every 16th tick since reset
        for (int m = 1; m <= 3; m++) begin
            int e;
            wr(8'h26, 8'(m));
            wr(8'h27, 8'h30);
            wr(8'h27, 8'h0A);   // start B, enable B
            e = ((ticks / 16) + 1) * 16 + (m - 1) * 16;
            while (ticks < e) begin
                tick();
                chk("R6 narrow expiry", int'(status[1]), (ticks == e) ? 1 : 0);
            end
            wr(8'h27, 8'h2A);   // clear B flag, keep running
            e = e + m * 16;
            while (ticks < e) begin
                tick();
                chk("R6 narrow reload", int'(status[1]), (ticks == e) ? 1 : 0);
            end
        end

        // R8 R9: selective flag clearing and irq hold
        wr(8'h27, 8'h00);       // stop both, flag B stays set
        chk("R9 held after stop", int'(irq), 1);
        set_a(2);
        wr(8'h27, 8'h05);
        run_a("R8 set A", 2, 1'b1);
        wr(8'h27, 8'h00);
        chk("R8 both set", int'(status[1:0]), 3);
        wr(8'h27, 8'h10);
        chk("R8 clear A only", int'(status[1:0]), 2);
        chk("R9 irq from B", int'(irq), 1);
        wr(8'h27, 8'h20);
        chk("R8 clear B", int'(status[1:0]), 0);
        chk("R9 irq low", int'(irq), 0);

        // R11: config bits held, no effect on flags
        wr(8'h27, 8'hC0);
        chk("R11 cfg set", int'({cfg_auto_key, cfg_three_slot}), 3);
        chk("R11 flags", int'(status[1:0]), 0);
        wr(8'h27, 8'h40);
        chk("R11 cfg partial", int'({cfg_auto_key, cfg_three_slot}), 1);
        wr(8'h27, 8'h00);
        chk("R11 cfg clear", int'({cfg_auto_key, cfg_three_slot}), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule